// File: doc/BRIEF.md
# Platform Abstraction Register Bank

A small memory-mapped control block for a multiprocessor system. It sits on a byte-addressed bus that carries read and write strobes, a byte address, byte-lane enables and the index of the processor issuing the access. It decodes a 32-byte window of word-aligned registers. Through these registers the processors can request a halt with an exit code, learn their own index and the processor count, set the level of each processor's interrupt line, and exchange bytes with a console.

The console traffic uses two valid/ready streams. On the input side the block accepts a byte when `cin_valid` and `cin_ready` are both high at a clock edge. `cin_ready` stays low while the one-byte input holder is occupied, so an upstream source must hold its byte until the processors read it out. On the output side `cout_valid` stays high and `cout_data` stays stable until `cout_ready` is seen high at an edge, so a slow console simply stalls the holder. Software sees that stall as an output status of zero. Offsets from 32 upward belong to a separate timer unit and read as zero here.

Byte lane i of the 32-bit data bus (bits 8i+7..8i) carries the byte at word address + i. Read data comes back registered, one cycle after the read strobe, marked by `bus_rvalid`. Only lane 0 can be nonzero.

Top module: `plat_regbank`

## Requirements
- R1: After synchronous reset `irq` is all zero, `halt_req`, `cout_valid` and `bus_rvalid` are low, and `cin_ready` is high.
- R2: A write to offset 0 with lane 0 enabled sets `halt_req` on the next cycle and puts lane 0's byte on `halt_code`. Both then hold until reset, and later halt writes leave the code unchanged.
- R3: A read of offset 4 returns the requesting processor's index from `bus_cpu` in lane 0.
- R4: A read of offset 12 returns the parameter NCPU in lane 0.
- R5: A write to offset 8 with lane 0 enabled selects port p = lane 0 byte. `irq[p]` becomes 1 when the lane 1 byte is nonzero and 0 otherwise. If lane 1 is not enabled, the level is taken as 0. Every line holds its value until it is rewritten.
- R6: An interrupt write whose port byte is NCPU or greater changes no `irq` line.
- R7: The input holder accepts a byte while empty (`cin_ready` high). While it holds a byte, offset 20 reads 1, and offset 16 returns the byte and empties the holder. When the holder is empty, offset 20 reads 0 and offset 16 reads 0.
- R8: Offset 28 reads 1 when the output holder is empty. A write to offset 24 with lane 0 enabled while it is empty loads that byte onto `cout_data` with `cout_valid` high until the `cout_ready` handshake. A write while it is occupied is dropped.
- R9: Lanes 1 to 3 of read data are always zero. Write-only offsets (0, 8, 24), misaligned addresses and offsets 32 and up read as zero. Writes to offsets with no write function change nothing.
- R10: `bus_rvalid` is high exactly in the cycle after each read strobe. The data reflects register state as it was in the strobe cycle, before any update at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | AW | Byte address within the window |
| bus_be | input | BEW | Byte-lane enables |
| bus_wdata | input | DW | Write data |
| bus_cpu | input | CPUW | Index of the requesting processor |
| bus_rdata | output | DW | Read data, registered |
| bus_rvalid | output | 1 | Read data valid |
| irq | output | NCPU | Per-processor level interrupt lines |
| halt_req | output | 1 | Halt request, sticky |
| halt_code | output | 8 | Exit status for the halt |
| cin_valid | input | 1 | Console input byte valid |
| cin_ready | output | 1 | Input holder can accept |
| cin_data | input | 8 | Console input byte |
| cout_valid | output | 1 | Console output byte valid |
| cout_ready | input | 1 | Console accepts output byte |
| cout_data | output | 8 | Console output byte |

## Verification
Two pairs of functions can land on the same edge. In the first, the console drains the output holder while a processor writes a new byte to it. The bench raises `cout_ready` in the same cycle as the data write, and it expects the write to be dropped, because the status seen in that cycle was zero. The result is judged from `cout_valid` falling and the output status then reading 1. In the second, a byte arrives on the input stream in the same cycle that the input status is read. The scoreboard expects 0 for that read and 1 for the read after it, and then expects the arrived byte from the data register.

// File: rtl/plat_pkg.sv
package plat_pkg;

  typedef enum logic [3:0] {
    RS_NONE,
    RS_HALT,
    RS_CPUID,
    RS_IRQ,
    RS_NCPU,
    RS_CIN_DATA,
    RS_CIN_STAT,
    RS_COUT_DATA,
    RS_COUT_STAT
  } reg_sel_e;

  // word index inside the 32-byte window -> register
  function automatic reg_sel_e word_to_sel(input logic [2:0] w);
    case (w)
      3'd0:    return RS_HALT;
      3'd1:    return RS_CPUID;
      3'd2:    return RS_IRQ;
      3'd3:    return RS_NCPU;
      3'd4:    return RS_CIN_DATA;
      3'd5:    return RS_CIN_STAT;
      3'd6:    return RS_COUT_DATA;
      default: return RS_COUT_STAT;
    endcase
  endfunction

endpackage

// File: rtl/plat_decode.sv
module plat_decode
  import plat_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic [AW-1:0] addr,
  output reg_sel_e      sel
);

  logic hi_clear;

  generate
    if (AW > 5) begin : g_hi
      assign hi_clear = ~|addr[AW-1:5];
    end else begin : g_nohi
      assign hi_clear = 1'b1;
    end
  endgenerate

  always_comb begin
    sel = RS_NONE;
    if (hi_clear && (addr[1:0] == 2'b00))
      sel = word_to_sel(addr[4:2]);
  end

endmodule

// File: rtl/plat_irq_bank.sv
module plat_irq_bank #(
  parameter int NCPU = 4,
  parameter int PW   = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [PW-1:0]   port,
  input  logic            level_en,
  input  logic [7:0]      level,
  output logic [NCPU-1:0] irq
);

  logic drive_high;
  assign drive_high = level_en && (|level);

  // one register per line; an out-of-range port matches no line
  generate
    for (genvar k = 0; k < NCPU; k++) begin : g_line
      always_ff @(posedge clk) begin
        if (rst)
          irq[k] <= 1'b0;
        else if (we && (port == PW'(k)))
          irq[k] <= drive_high;
      end
    end
  endgenerate

endmodule

// File: rtl/plat_con_in.sv
module plat_con_in (
  input  logic       clk,
  input  logic       rst,
  input  logic       s_valid,
  output logic       s_ready,
  input  logic [7:0] s_data,
  input  logic       pop,
  output logic       have,
  output logic [7:0] data
);

  logic       full_q;
  logic [7:0] byte_q;

  assign s_ready = !full_q;
  assign have    = full_q;
  assign data    = full_q ? byte_q : 8'h00;

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q <= 1'b0;
      byte_q <= 8'h00;
    end else if (s_valid && !full_q) begin
      full_q <= 1'b1;
      byte_q <= s_data;
    end else if (pop) begin
      full_q <= 1'b0;
    end
  end

endmodule

// File: rtl/plat_con_out.sv
module plat_con_out (
  input  logic       clk,
  input  logic       rst,
  input  logic       push,
  input  logic [7:0] push_data,
  output logic       room,
  output logic       m_valid,
  input  logic       m_ready,
  output logic [7:0] m_data
);

  logic       full_q;
  logic [7:0] byte_q;

  assign room    = !full_q;
  assign m_valid = full_q;
  assign m_data  = byte_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q <= 1'b0;
      byte_q <= 8'h00;
    end else if (full_q) begin
      // a push seen while occupied is dropped, even if draining now
      if (m_ready) full_q <= 1'b0;
    end else if (push) begin
      full_q <= 1'b1;
      byte_q <= push_data;
    end
  end

endmodule

// File: rtl/plat_regbank.sv
module plat_regbank
  import plat_pkg::*;
#(
  parameter int NCPU = 4,
  parameter int AW   = 6,
  parameter int DW   = 32,
  parameter int BEW  = DW / 8,
  parameter int CPUW = (NCPU > 1) ? $clog2(NCPU) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [AW-1:0]   bus_addr,
  input  logic [BEW-1:0]  bus_be,
  input  logic [DW-1:0]   bus_wdata,
  input  logic [CPUW-1:0] bus_cpu,
  output logic [DW-1:0]   bus_rdata,
  output logic            bus_rvalid,
  output logic [NCPU-1:0] irq,
  output logic            halt_req,
  output logic [7:0]      halt_code,
  input  logic            cin_valid,
  output logic            cin_ready,
  input  logic [7:0]      cin_data,
  output logic            cout_valid,
  input  logic            cout_ready,
  output logic [7:0]      cout_data
);

  localparam int LANE = 8;

  reg_sel_e   sel;
  logic       wr_lane0;
  logic       in_have;
  logic [7:0] in_byte;
  logic       out_room;
  logic [7:0] rd_byte;
  logic       unused_hi;

  assign unused_hi = ^{bus_wdata[DW-1:2*LANE], bus_be[BEW-1:2]};

  plat_decode #(.AW(AW)) u_dec (
    .addr (bus_addr),
    .sel  (sel)
  );

  assign wr_lane0 = bus_wr && bus_be[0];

  plat_irq_bank #(.NCPU(NCPU), .PW(LANE)) u_irq (
    .clk      (clk),
    .rst      (rst),
    .we       (wr_lane0 && (sel == RS_IRQ)),
    .port     (bus_wdata[LANE-1:0]),
    .level_en (bus_be[1]),
    .level    (bus_wdata[2*LANE-1:LANE]),
    .irq      (irq)
  );

  plat_con_in u_cin (
    .clk     (clk),
    .rst     (rst),
    .s_valid (cin_valid),
    .s_ready (cin_ready),
    .s_data  (cin_data),
    .pop     (bus_rd && (sel == RS_CIN_DATA)),
    .have    (in_have),
    .data    (in_byte)
  );

  plat_con_out u_cout (
    .clk       (clk),
    .rst       (rst),
    .push      (wr_lane0 && (sel == RS_COUT_DATA)),
    .push_data (bus_wdata[LANE-1:0]),
    .room      (out_room),
    .m_valid   (cout_valid),
    .m_ready   (cout_ready),
    .m_data    (cout_data)
  );

  // halt: first write latches the code, then everything holds
  always_ff @(posedge clk) begin
    if (rst) begin
      halt_req  <= 1'b0;
      halt_code <= 8'h00;
    end else if (wr_lane0 && (sel == RS_HALT) && !halt_req) begin
      halt_req  <= 1'b1;
      halt_code <= bus_wdata[LANE-1:0];
    end
  end

  always_comb begin
    case (sel)
      RS_CPUID:     rd_byte = 8'(bus_cpu);
      RS_NCPU:      rd_byte = 8'(NCPU);
      RS_CIN_DATA:  rd_byte = in_byte;
      RS_CIN_STAT:  rd_byte = {7'b0, in_have};
      RS_COUT_STAT: rd_byte = {7'b0, out_room};
      default:      rd_byte = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= bus_rd;
      bus_rdata  <= bus_rd ? DW'(rd_byte) : '0;
    end
  end

endmodule

// File: rtl/plat_regbank_chk.sv
module plat_regbank_chk #(
  parameter int NCPU = 4,
  parameter int AW   = 6,
  parameter int DW   = 32,
  parameter int BEW  = DW / 8
) (
  input logic            clk,
  input logic            rst,
  input logic            bus_wr,
  input logic            bus_rd,
  input logic [AW-1:0]   bus_addr,
  input logic [BEW-1:0]  bus_be,
  input logic [DW-1:0]   bus_wdata,
  input logic [DW-1:0]   bus_rdata,
  input logic            bus_rvalid,
  input logic [NCPU-1:0] irq,
  input logic            halt_req,
  input logic [7:0]      halt_code,
  input logic            cin_valid,
  input logic            cin_ready,
  input logic            cout_valid,
  input logic            cout_ready,
  input logic [7:0]      cout_data
);

  logic irq_wr;
  assign irq_wr = bus_wr && bus_be[0] && (bus_addr == AW'(8));

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (irq == '0) && !halt_req && !cout_valid && !bus_rvalid && cin_ready);

  a_r2_halt_sticky: assert property (@(posedge clk) disable iff (rst)
    halt_req |=> halt_req && $stable(halt_code));

  a_r5_irq_hold: assert property (@(posedge clk) disable iff (rst)
    !irq_wr |=> $stable(irq));

  a_r6_port_range: assert property (@(posedge clk) disable iff (rst)
    (irq_wr && (int'(bus_wdata[7:0]) >= NCPU)) |=> $stable(irq));

  a_r7_in_full: assert property (@(posedge clk) disable iff (rst)
    (cin_valid && cin_ready) |=> !cin_ready);

  a_r8_out_hold: assert property (@(posedge clk) disable iff (rst)
    (cout_valid && !cout_ready) |=> cout_valid && $stable(cout_data));

  a_r9_upper_zero: assert property (@(posedge clk) disable iff (rst)
    bus_rvalid |-> (bus_rdata[DW-1:8] == '0));

  a_r10_rvalid_on: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> bus_rvalid);

  a_r10_rvalid_off: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> !bus_rvalid);

endmodule

bind plat_regbank plat_regbank_chk #(
  .NCPU(NCPU), .AW(AW), .DW(DW), .BEW(BEW)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_wr     (bus_wr),
  .bus_rd     (bus_rd),
  .bus_addr   (bus_addr),
  .bus_be     (bus_be),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .bus_rvalid (bus_rvalid),
  .irq        (irq),
  .halt_req   (halt_req),
  .halt_code  (halt_code),
  .cin_valid  (cin_valid),
  .cin_ready  (cin_ready),
  .cout_valid (cout_valid),
  .cout_ready (cout_ready),
  .cout_data  (cout_data)
);

// File: tb/plat_regbank_bench.sv
`timescale 1ns/1ps
module plat_regbank_bench;

  localparam int NCPU = 4;
  localparam int AW   = 6;
  localparam int DW   = 32;
  localparam int BEW  = 4;
  localparam int CPUW = 2;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            bus_wr = 1'b0, bus_rd = 1'b0;
  logic [AW-1:0]   bus_addr = '0;
  logic [BEW-1:0]  bus_be = '0;
  logic [DW-1:0]   bus_wdata = '0;
  logic [CPUW-1:0] bus_cpu = '0;
  logic [DW-1:0]   bus_rdata;
  logic            bus_rvalid;
  logic [NCPU-1:0] irq;
  logic            halt_req;
  logic [7:0]      halt_code;
  logic            cin_valid = 1'b0;
  logic            cin_ready;
  logic [7:0]      cin_data = '0;
  logic            cout_valid;
  logic            cout_ready = 1'b0;
  logic [7:0]      cout_data;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [DW-1:0] exp_q[$];
  string         tag_q[$];

  always #2.5 clk = ~clk;

  plat_regbank #(.NCPU(NCPU), .AW(AW), .DW(DW)) u_plat_regbank (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_cpu(bus_cpu), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .irq(irq), .halt_req(halt_req), .halt_code(halt_code),
    .cin_valid(cin_valid), .cin_ready(cin_ready), .cin_data(cin_data),
    .cout_valid(cout_valid), .cout_ready(cout_ready), .cout_data(cout_data)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pops one expected item per returned read
  always @(negedge clk) begin
    if (!rst && bus_rvalid) begin
      if (exp_q.size() == 0) check("R10 unexpected rvalid", 32'h1, 32'h0);
      else check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
    end
  end

  task automatic drive_wr(int a, logic [3:0] be, logic [31:0] d);
    bus_wr = 1'b1; bus_addr = AW'(a); bus_be = be; bus_wdata = d;
  endtask

  task automatic drive_rd(int a, int cpu, logic [31:0] exp, string tag);
    bus_rd = 1'b1; bus_addr = AW'(a); bus_cpu = CPUW'(cpu);
    exp_q.push_back(exp); tag_q.push_back(tag);
  endtask

  task automatic idle();
    bus_wr = 1'b0; bus_rd = 1'b0; bus_be = '0;
  endtask

  task automatic wr(int a, logic [3:0] be, logic [31:0] d);
    @(negedge clk); drive_wr(a, be, d);
    @(negedge clk); idle();
  endtask

  task automatic rd(int a, logic [31:0] exp, string tag, int cpu = 0);
    @(negedge clk); drive_rd(a, cpu, exp, tag);
    @(negedge clk); idle();
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 irq", 32'(irq), 0);
    check("R1 halt_req", 32'(halt_req), 0);
    check("R1 cout_valid", 32'(cout_valid), 0);
    check("R1 rvalid", 32'(bus_rvalid), 0);
    check("R1 cin_ready", 32'(cin_ready), 1);

    // R3 processor id, R4 count
    rd(4, 32'h2, "R3 id cpu2", 2);
    rd(4, 32'h3, "R3 id cpu3", 3);
    rd(4, 32'h0, "R3 id cpu0", 0);
    rd(12, 32'h4, "R4 count");

    // R5 interrupt lines
    wr(8, 4'b0011, 32'h0000_0102);
    check("R5 port2 high", 32'(irq), 32'h4);
    wr(8, 4'b0011, 32'h0000_0500);
    check("R5 port0 high", 32'(irq), 32'h5);
    wr(8, 4'b0001, 32'h0000_FF02);
    check("R5 no level lane", 32'(irq), 32'h1);
    repeat (3) @(negedge clk);
    check("R5 hold", 32'(irq), 32'h1);

    // R6 out-of-range port
    wr(8, 4'b0011, 32'h0000_0104);
    check("R6 port4", 32'(irq), 32'h1);
    wr(8, 4'b0011, 32'h0000_01FF);
    check("R6 portFF", 32'(irq), 32'h1);

    // R9 write-only / unmapped / misaligned reads
    rd(0, 0, "R9 halt reads zero");
    rd(8, 0, "R9 irq reads zero");
    rd(24, 0, "R9 out data reads zero");
    rd(32, 0, "R9 timer window");
    rd(44, 0, "R9 timer window hi");
    rd(6, 0, "R9 misaligned");
    wr(36, 4'b1111, 32'hFFFF_FF01);
    wr(20, 4'b1111, 32'h0000_0001);
    wr(13, 4'b1111, 32'h0000_0001);
    check("R9 unmapped write irq", 32'(irq), 32'h1);
    check("R9 unmapped write halt", 32'(halt_req), 0);
    rd(20, 0, "R9 status not writable");

    // R7 console input
    rd(20, 0, "R7 empty status");
    @(negedge clk); cin_valid = 1'b1; cin_data = 8'h41;
    @(negedge clk); cin_valid = 1'b0;
    check("R7 ready low when full", 32'(cin_ready), 0);
    rd(20, 1, "R7 status full");
    rd(16, 32'h41, "R7 data");
    rd(20, 0, "R7 status after pop");
    check("R7 ready after pop", 32'(cin_ready), 1);
    rd(16, 0, "R7 empty data");

    // R8 console output
    rd(28, 1, "R8 room");
    wr(24, 4'b0001, 32'h0000_005A);
    check("R8 valid", 32'(cout_valid), 1);
    check("R8 data", 32'(cout_data), 32'h5A);
    rd(28, 0, "R8 full status");
    wr(24, 4'b0001, 32'h0000_0033);
    check("R8 drop when full", 32'(cout_data), 32'h5A);
    @(negedge clk); cout_ready = 1'b1;
    @(negedge clk); cout_ready = 1'b0;
    check("R8 retired", 32'(cout_valid), 0);
    rd(28, 1, "R8 room again");

    // collision: drain and write on the same edge
    wr(24, 4'b0001, 32'h0000_0061);
    @(negedge clk); cout_ready = 1'b1; drive_wr(24, 4'b0001, 32'h0000_0062);
    @(negedge clk); cout_ready = 1'b0; idle();
    check("R8 collision write dropped", 32'(cout_valid), 0);
    rd(28, 1, "R8 collision status");

    // collision: arrival and status read on the same edge (R10)
    @(negedge clk); cin_valid = 1'b1; cin_data = 8'h7E;
    drive_rd(20, 0, 0, "R10 status before arrival");
    @(negedge clk); cin_valid = 1'b0; idle();
    rd(20, 1, "R10 status after arrival");
    rd(16, 32'h7E, "R7 collision data");

    // R2 halt
    wr(0, 4'b0001, 32'h0000_0037);
    check("R2 halt_req", 32'(halt_req), 1);
    check("R2 halt_code", 32'(halt_code), 32'h37);
    wr(0, 4'b0001, 32'h0000_0099);
    check("R2 code kept", 32'(halt_code), 32'h37);
    check("R2 still halted", 32'(halt_req), 1);

    repeat (2) @(negedge clk);
    check("R10 all reads returned", exp_q.size(), 0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule